// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Command/Data Start-Bit

This block is the controller side of a single-channel SPI link. One transfer moves one word in each direction: a pulse on `start_i` captures the transmit word, its length, the clock phase, the start-bit enable and the clock divider. The block then lowers the chip-select, generates the serial clock from the functional clock, shifts the word out on MOSI most-significant bit first and assembles the MISO bits in the same order. The serial clock idles low.

When start-bit mode is on, one extra bit leads the word. It is 1 for a data word and 0 for a command word. MISO is not sampled during that slot. With phase 0 the first bit is on the line as soon as chip-select falls, and the first clock edge samples it. With phase 1 a half-period synchronization gap follows chip-select, and the first edge launches the first bit. After the last edge the chip-select stays low for half a period and then rises. In the next cycle a one-cycle done pulse marks the received word as valid.

Top module: `spi_sbit_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 0, `mosi_oe_o` is 0 and `done_o` is 0.
- R2: `mosi_oe_o` is 1 exactly while `cs_n_o` is 0, and `sclk_o` is 0 whenever `cs_n_o` is 1.
- R3: A word of `len_i` bits (4 to 32) goes out on MOSI MSB first, and its bit value is taken from `tx_word_i[len_i-1:0]`. Without a start-bit the clock gives exactly `len_i` rising edges.
- R4: With `pha_i`=0, MOSI carries the first frame bit in the first cycle that chip-select is low. MOSI is sampled on rising (odd) edges and changes on falling (even) edges.
- R5: With `pha_i`=1, the first clock edge comes half a period after chip-select falls and presents the first frame bit. MOSI changes on rising edges, and MISO is sampled on falling (even) edges.
- R6: Every serial-clock half period, including the gap between chip-select falling and the first edge, lasts `half_i`+1 functional-clock cycles. The divide ratio is therefore 2*(`half_i`+1), from 2 to 256.
- R7: With `sbe_i`=1, one extra bit equal to `data_flag_i` (1 = data, 0 = command) goes out before the MSB, and the clock gives `len_i`+1 rising edges. The MISO value in that first slot has no effect on `rx_word_o`.
- R8: `cs_n_o` rises `half_i`+1 cycles after the last clock edge. `done_o` is then high for exactly one cycle, the cycle after the rise. At that point `rx_word_o` holds the `len_i` received bits right-aligned, with the first received bit as the MSB and the upper bits zero.
- R9: A `start_i` pulse during a transfer is ignored. The frame on MOSI still comes from the word that was captured at the start.
- R10: While chip-select stays low, MOSI changes only in a cycle in which `sclk_o` also toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only while idle) |
| len_i | input | 6 | Word length in bits, 4..32 |
| pha_i | input | 1 | Clock phase select |
| sbe_i | input | 1 | Prepend a command/data start-bit |
| half_i | input | 7 | Half-period length minus one, in functional-clock cycles |
| data_flag_i | input | 1 | Start-bit value: 1 data, 0 command |
| tx_word_i | input | 32 | Word to send, right-aligned |
| miso_i | input | 1 | Serial data from the peripheral |
| cs_n_o | output | 1 | Active-low chip-select |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| mosi_oe_o | output | 1 | Output enable for MOSI (high impedance when 0) |
| rx_word_o | output | 32 | Received word, right-aligned |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The assertions assume that `len_i` lies within 4 to 32 when `start_i` is taken, and that MISO settles before the functional-clock edge on which the serial clock makes a sampling transition. The bench sweeps every legal length, both phases and both start-bit settings at small dividers, plus one run at the largest divider. It keeps the configuration legal throughout. It acts as the peripheral and changes MISO at the negative functional-clock edge just after each sampling edge, so MISO is always stable half a period ahead of the next sample.

// File: rtl/spi_sbit_ctrl.sv
module spi_sbit_ctrl #(
  parameter int MAXW = 32,
  parameter int DIVW = 7,
  localparam int LW = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [LW-1:0]   len_i,
  input  logic            pha_i,
  input  logic            sbe_i,
  input  logic [DIVW-1:0] half_i,
  input  logic            data_flag_i,
  input  logic [MAXW-1:0] tx_word_i,
  input  logic            miso_i,
  output logic            cs_n_o,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            mosi_oe_o,
  output logic [MAXW-1:0] rx_word_o,
  output logic            done_o
);
  localparam int FW = MAXW + 1;
  localparam int EW = $clog2(2 * FW + 1);
  localparam logic [EW-1:0] E1 = EW'(1);
  localparam logic [EW-1:0] E2 = EW'(2);

  logic            busy, pha_q, sbe_q, pend;
  logic [DIVW-1:0] half_q, cnt;
  logic [EW-1:0]   edge_n, last_q;
  logic [FW-1:0]   tx_sh;
  logic [MAXW-1:0] rx_sh;

  wire [MAXW-1:0] aligned = tx_word_i << (MAXW - int'(len_i));
  wire [FW-1:0]   frame   = sbe_i ? {data_flag_i, aligned} : {aligned, 1'b0};

  wire          tick     = busy && (cnt == '0);
  wire [EW-1:0] k        = edge_n + E1;
  wire          samp_e   = pha_q ? ~k[0] : k[0];
  wire          slot0    = sbe_q && (k == (pha_q ? E2 : E1));
  wire          shift_e  = !samp_e && !(pha_q ? (k == E1) : (k == last_q));

  assign mosi_oe_o = ~cs_n_o;
  assign mosi_o    = ~cs_n_o & tx_sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pha_q <= 1'b0; sbe_q <= 1'b0; pend <= 1'b0;
      half_q <= '0; cnt <= '0; edge_n <= '0; last_q <= '0;
      tx_sh <= '0; rx_sh <= '0; rx_word_o <= '0;
      cs_n_o <= 1'b1; sclk_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= pend;
      pend   <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy   <= 1'b1;
          cs_n_o <= 1'b0;
          pha_q  <= pha_i;
          sbe_q  <= sbe_i;
          half_q <= half_i;
          cnt    <= half_i;
          edge_n <= '0;
          last_q <= EW'(2 * (int'(len_i) + int'(sbe_i)));
          tx_sh  <= frame;
          rx_sh  <= '0;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= half_q;
        if (edge_n == last_q) begin
          busy      <= 1'b0;
          cs_n_o    <= 1'b1;
          pend      <= 1'b1;
          rx_word_o <= rx_sh;
        end else begin
          edge_n <= k;
          sclk_o <= ~sclk_o;
          if (samp_e && !slot0) rx_sh <= {rx_sh[MAXW-2:0], miso_i};
          if (shift_e) tx_sh <= {tx_sh[FW-2:0], 1'b0};
        end
      end
    end
  end

  assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  assert_clock_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> (!cs_n_o && !$past(cs_n_o)));
  assert_first_edge_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !sclk_o);
  assert_mosi_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !$past(cs_n_o) && !$stable(mosi_o)) |-> !$stable(sclk_o));
  assert_done_follows_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> done_o);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o ##1 !done_o));
endmodule

// File: tb/test_spi_sbit_ctrl.sv
`timescale 1ns/1ps
module test_spi_sbit_ctrl;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, pha_i = 0, sbe_i = 0, data_flag_i = 0, miso_i = 0;
  logic [5:0] len_i = 6'd8;
  logic [6:0] half_i = '0;
  logic [31:0] tx_word_i = '0;
  logic cs_n_o, sclk_o, mosi_o, mosi_oe_o, done_o;
  logic [31:0] rx_word_o;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  spi_sbit_ctrl i_spi_sbit_ctrl (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  int cur_len; bit cur_sbe; logic [31:0] cur_sw;
  function automatic logic mb(int j);
    int i = j - (cur_sbe ? 1 : 0);
    if (cur_sbe && j == 0) return ~cur_sw[cur_len-1];
    if (i < cur_len) return cur_sw[cur_len-1-i];
    return 1'b0;
  endfunction

  task automatic xfer(int len, bit pha, bit sbe, int hm1, logic [31:0] w,
                      logic [31:0] sw, bit isd, bit inj);
    int h = hm1 + 1, n = len + (sbe ? 1 : 0);
    logic [63:0] mask, expf, got = '0, rx = '0;
    int edges = 0, rises = 0, samp = 0, since = 0, gapbad = 0, monbad = 0, movbad = 0;
    int csrise = -1, donec = -1, tail = -1;
    bit fin = 0, firstok, prev_s, prev_m, prev_cs;
    mask = (64'd1 << len) - 1;
    expf = sbe ? ((64'(isd) << len) | (64'(w) & mask)) : (64'(w) & mask);
    cur_len = len; cur_sbe = sbe; cur_sw = sw;
    @(negedge clk);
    len_i = 6'(len); pha_i = pha; sbe_i = sbe; half_i = 7'(hm1);
    tx_word_i = w; data_flag_i = isd; start_i = 1;
    @(negedge clk);
    start_i = 0;
    firstok = pha ? 1'b1 : (cs_n_o == 0 && sclk_o == 0 && mosi_o == expf[n-1]);
    miso_i = mb(0);
    prev_s = sclk_o; prev_m = mosi_o; prev_cs = cs_n_o;
    for (int c = 1; c < 6000; c++) begin
      @(negedge clk);
      if (inj && c == 2) begin start_i = 1; tx_word_i = ~w; data_flag_i = ~isd; end
      if (inj && c == 3) start_i = 0;
      since++;
      if (sclk_o != prev_s) begin
        edges++;
        if (sclk_o) rises++;
        if (since != h) gapbad++;
        since = 0;
        if (pha && edges == 1) firstok = sclk_o && mosi_o == expf[n-1];
        if (pha ? !sclk_o : sclk_o) begin
          got = {got[62:0], mosi_o};
          samp++;
          miso_i = mb(samp);
        end
      end else if (!cs_n_o && !prev_cs && mosi_o != prev_m) movbad++;
      if (mosi_oe_o != !cs_n_o || (cs_n_o && sclk_o)) monbad++;
      if (cs_n_o && !prev_cs) begin csrise = c; tail = since; end
      if (done_o) begin donec = c; rx = 64'(rx_word_o); fin = 1; end
      prev_s = sclk_o; prev_m = mosi_o; prev_cs = cs_n_o;
      if (fin) break;
    end
    @(negedge clk);
    chk(firstok, pha ? "R5 first bit at first edge" : "R4 first bit at cs fall", 64'(firstok), 1);
    chk(gapbad == 0, "R6 half-period length", 64'(gapbad), 0);
    chk(rises == n && edges == 2 * n, sbe ? "R7 pulse count" : "R3 pulse count", 64'(rises), 64'(n));
    chk(got == expf && samp == n, inj ? "R9 frame after ignored start" : (sbe ? "R7 start-bit frame" : "R3 MSB-first frame"), got, expf);
    chk(tail == h, "R8 cs tail", 64'(tail), 64'(h));
    chk(fin && donec == csrise + 1 && done_o == 0, "R8 done pulse timing", 64'(donec), 64'(csrise + 1));
    chk(rx == (64'(sw) & mask), sbe ? "R7 rx ignores start slot" : "R8 rx word", rx, 64'(sw) & mask);
    chk(monbad == 0, "R2 output enable and idle clock", 64'(monbad), 0);
    chk(movbad == 0, "R10 mosi moves only on edges", 64'(movbad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1 && sclk_o == 0 && mosi_oe_o == 0 && done_o == 0, "R1 reset state",
        {cs_n_o, sclk_o, mosi_oe_o, done_o}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n_o == 1 && sclk_o == 0 && done_o == 0, "R1 idle after reset",
        {cs_n_o, sclk_o, done_o}, 3'b100);
    for (int len = 4; len <= 32; len++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 2; d++)
            xfer(len, p[0], s[0], d * 2, 32'hA5C3_961E ^ (32'(len) * 32'h0101_0F07),
                 32'h3C5A_F00F + 32'(len) * 32'd77777 + 32'(p * 13), len[0] ^ s[0],
                 len % 7 == 2);
    xfer(4, 1'b0, 1'b1, 127, 32'h9, 32'h6, 1'b0, 1'b0);
    xfer(32, 1'b1, 1'b1, 5, 32'hFFFF_0001, 32'h8000_7FFE, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule